// File: doc/BRIEF.md
# UART Receive FIFO with Fill Trigger and Idle Timeout

This block holds received characters for a serial port until the bus side reads them. It stores up to sixteen bytes in arrival order. The bytes come from the receiver or from a loopback path. The block gives the interrupt unit three level status bits and two single-cycle event pulses:

- The level bits are empty, full and fill-level trigger.
- The overrun pulse fires when a byte arrives while the store is already full.
- The idle-timeout pulse fires once four character times have passed with no new byte accepted.

A receiver-enable input gates both the write side and the read side. A synchronous flush empties the store. The trigger threshold comes in from a programmable register elsewhere in the chip. A strobe that pulses once per character duration paces the timeout. The read data is combinational from the head entry, so a bus read samples `rd_data` in the same cycle that it raises `rd_en`.

Top module: `uart_rx_fifo`

## Requirements
- R1: Accepted bytes are returned on `rd_data` in arrival order. The store holds up to DEPTH (16) bytes. `rd_data` shows the oldest byte while the store is non-empty and the receiver is enabled.
- R2: `empty` is 1 exactly when the store holds no byte. `full` is 1 exactly when it holds DEPTH bytes. A read from a full store clears `full` on the next clock.
- R3: A write while the store holds DEPTH bytes is dropped and the contents stay unchanged. `overrun` is then 1 for exactly the one cycle after that clock edge.
- R4: After an accepted write, `trig` becomes 1 if the new count is greater than or equal to `trig_level`.
- R5: After an accepted read, `trig` becomes 0 if the new count is below `trig_level`. Otherwise `trig` keeps its value.
- R6: While the store is empty, `rd_data` is 0 and a read leaves every output unchanged.
- R7: Each accepted write restarts the idle timer. On the fourth `char_tick` after the latest accepted byte, `rx_timeout` pulses high for one cycle. It does not pulse again until another byte is accepted.
- R8: While `rx_en` is 0, writes and reads have no effect on the contents or the status, and `rd_data` is 0.
- R9: `flush` empties the store, sets `empty`, clears `full` and `trig`, and cancels a pending timeout. It takes priority over a write or read in the same cycle.
- R10: A write and a read in the same cycle both take effect. The count stays the same and byte order is kept.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_en | input | 1 | Receiver enable; gates writes and reads |
| flush | input | 1 | Synchronous clear of the store and timer |
| wr_en | input | 1 | Write strobe from the receiver or loopback path |
| wr_data | input | WIDTH | Byte to store |
| rd_en | input | 1 | Read strobe from the bus data register |
| rd_data | output | WIDTH | Oldest stored byte, or 0 when empty or disabled |
| trig_level | input | $clog2(DEPTH+1)+1 | Fill-level trigger threshold |
| char_tick | input | 1 | One pulse per character duration |
| empty | output | 1 | Store holds no byte |
| full | output | 1 | Store holds DEPTH bytes |
| trig | output | 1 | Fill-level trigger status |
| overrun | output | 1 | One-cycle pulse on a dropped write |
| rx_timeout | output | 1 | One-cycle pulse after four idle character times |

## Verification
The bench fills the store to exactly sixteen bytes and then pushes a seventeenth. A design with an off-by-one on the count would either keep the extra byte, so it shows up in the readback, or fail to pulse overrun. The idle timer is restarted just before it would expire, and it is also cancelled by a flush. A design that does not restart, or does not disarm, would pulse `rx_timeout` early or after the flush. The bench also issues a read and a write in one cycle, and it issues reads and writes with the receiver disabled. A wrong count update would then show as a short or long readback, and a missing enable gate would leak data.

// File: rtl/uart_rx_fifo.sv
module uart_rx_fifo #(
  parameter int DEPTH         = 16,
  parameter int WIDTH         = 8,
  parameter int TIMEOUT_CHARS = 4,
  parameter int AW            = $clog2(DEPTH),
  parameter int CW            = $clog2(DEPTH + 1),
  parameter int LW            = CW + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_en,
  input  logic             flush,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             rd_en,
  output logic [WIDTH-1:0] rd_data,
  input  logic [LW-1:0]    trig_level,
  input  logic             char_tick,
  output logic             empty,
  output logic             full,
  output logic             trig,
  output logic             overrun,
  output logic             rx_timeout
);
  localparam int TW = (TIMEOUT_CHARS > 2) ? $clog2(TIMEOUT_CHARS) : 1;

  logic [WIDTH-1:0] mem [DEPTH];
  logic [CW-1:0]    cnt, cnt_nx;
  logic [AW-1:0]    wptr, rptr;
  logic [TW-1:0]    tmo_cnt;
  logic             tmo_arm;
  logic             wr_acc, rd_acc;

  assign empty  = (cnt == '0);
  assign full   = (cnt == CW'(DEPTH));
  assign wr_acc = rx_en & ~flush & wr_en & ~full;
  assign rd_acc = rx_en & ~flush & rd_en & ~empty;
  assign cnt_nx = cnt + CW'(wr_acc) - CW'(rd_acc);
  assign rptr   = wptr - cnt[AW-1:0];
  assign rd_data = (rx_en && !empty) ? mem[rptr] : '0;

  always_ff @(posedge clk)
    if (wr_acc) mem[wptr] <= wr_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt        <= '0;
      wptr       <= '0;
      trig       <= 1'b0;
      overrun    <= 1'b0;
      rx_timeout <= 1'b0;
      tmo_arm    <= 1'b0;
      tmo_cnt    <= '0;
    end else begin
      overrun    <= rx_en & ~flush & wr_en & full;
      rx_timeout <= 1'b0;
      if (flush) begin
        cnt     <= '0;
        wptr    <= '0;
        trig    <= 1'b0;
        tmo_arm <= 1'b0;
        tmo_cnt <= '0;
      end else begin
        cnt <= cnt_nx;
        if (wr_acc) wptr <= wptr + AW'(1);
        if (wr_acc && {1'b0, cnt_nx} >= trig_level) trig <= 1'b1;
        if (rd_acc && {1'b0, cnt_nx} <  trig_level) trig <= 1'b0;
        if (wr_acc) begin
          tmo_arm <= 1'b1;
          tmo_cnt <= '0;
        end else if (tmo_arm && char_tick) begin
          if (tmo_cnt == TW'(TIMEOUT_CHARS - 1)) begin
            rx_timeout <= 1'b1;
            tmo_arm    <= 1'b0;
          end else begin
            tmo_cnt <= tmo_cnt + TW'(1);
          end
        end
      end
    end
  end

  a_r1_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DEPTH));
  a_r2_read_clears_full: assert property (@(posedge clk) disable iff (!rst_n)
    (full && rx_en && rd_en && !wr_en && !flush) |=> !full);
  a_r3_overrun_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (full && rx_en && wr_en && !flush) |=> (overrun && $stable(cnt)));
  a_r7_timeout_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    rx_timeout |-> $past(char_tick));
  a_r8_disabled_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_en && !flush) |=> ($stable(cnt) && $stable(wptr)));
  a_r9_flush_clears: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (empty && !trig && !rx_timeout));
  a_r10_both_keep_count: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_en && wr_en && rd_en && !flush && !empty && !full) |=> $stable(cnt));
endmodule

// File: tb/test_uart_rx_fifo.sv
module test_uart_rx_fifo;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx_en = 1'b0, flush = 1'b0, wr_en = 1'b0, rd_en = 1'b0, char_tick = 1'b0;
  logic [7:0] wr_data = '0;
  logic [5:0] trig_level = 6'd32;
  logic [7:0] rd_data;
  logic       empty, full, trig, overrun, rx_timeout;

  int checks = 0, errors = 0;
  logic [7:0] q[$];
  logic mtrig = 1'b0;

  always #10 clk = ~clk;

  uart_rx_fifo i_uart_rx_fifo (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .flush(flush), .wr_en(wr_en),
    .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data), .trig_level(trig_level),
    .char_tick(char_tick), .empty(empty), .full(full), .trig(trig),
    .overrun(overrun), .rx_timeout(rx_timeout));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic chk_status(input string req);
    chk({req, " empty"}, 32'(empty), 32'(q.size() == 0));
    chk({req, " full"}, 32'(full), 32'(q.size() == 16));
    chk({req, " trig"}, 32'(trig), 32'(mtrig));
  endtask

  task automatic push(input logic [7:0] b);
    logic ovr_exp = 1'b0;
    @(negedge clk); wr_en = 1'b1; wr_data = b;
    @(negedge clk); wr_en = 1'b0;
    if (rx_en) begin
      if (q.size() < 16) begin
        q.push_back(b);
        if (q.size() >= int'(trig_level)) mtrig = 1'b1;
      end else ovr_exp = 1'b1;
    end
    chk("R3 overrun", 32'(overrun), 32'(ovr_exp));
    chk_status("R2/R4 after write");
  endtask

  task automatic pop();
    logic [7:0] exp;
    @(negedge clk); rd_en = 1'b1;
    exp = (rx_en && q.size() != 0) ? q[0] : 8'h00;
    chk("R1/R6/R8 rd_data", 32'(rd_data), 32'(exp));
    @(negedge clk); rd_en = 1'b0;
    if (rx_en && q.size() != 0) begin
      void'(q.pop_front());
      if (q.size() < int'(trig_level)) mtrig = 1'b0;
    end
    chk_status("R2/R5 after read");
  endtask

  task automatic tick(input logic exp_to);
    @(negedge clk); char_tick = 1'b1;
    @(negedge clk); char_tick = 1'b0;
    chk("R7 rx_timeout", 32'(rx_timeout), 32'(exp_to));
  endtask

  task automatic do_flush();
    @(negedge clk); flush = 1'b1;
    @(negedge clk); flush = 1'b0;
    q.delete(); mtrig = 1'b0;
    chk_status("R9 flush");
    chk("R9 rd_data after flush", 32'(rd_data), 32'h0);
  endtask

  initial begin
    #4ms;
    errors++; checks++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk_status("R2 reset");
    chk("R6 reset rd_data", 32'(rd_data), 32'h0);
    chk("R3 reset overrun", 32'(overrun), 32'h0);
    chk("R7 reset timeout", 32'(rx_timeout), 32'h0);
    rx_en = 1'b1;

    push(8'h11); push(8'h22); push(8'h33);
    pop(); pop(); pop();
    pop();

    trig_level = 6'd4;
    push(8'hA0); push(8'hA1); push(8'hA2);
    push(8'hA3);
    chk("R4 trig at level", 32'(trig), 32'h1);
    pop();
    chk("R5 trig below level", 32'(trig), 32'h0);
    pop(); pop(); pop();

    trig_level = 6'd32;
    for (int i = 0; i < 16; i++) push(8'(8'h40 + i));
    chk("R2 full at 16", 32'(full), 32'h1);
    push(8'hEE);
    @(negedge clk);
    chk("R3 overrun one cycle", 32'(overrun), 32'h0);
    pop();
    chk("R2 read clears full", 32'(full), 32'h0);
    for (int i = 0; i < 15; i++) pop();
    chk("R3 dropped byte absent", 32'(empty), 32'h1);

    push(8'h51); push(8'h52);
    @(negedge clk); wr_en = 1'b1; rd_en = 1'b1; wr_data = 8'h53;
    chk("R10 head during both", 32'(rd_data), 32'h51);
    @(negedge clk); wr_en = 1'b0; rd_en = 1'b0;
    void'(q.pop_front()); q.push_back(8'h53);
    chk_status("R10 after both");
    pop(); pop();
    chk("R10 empty after two reads", 32'(empty), 32'h1);

    push(8'h61);
    rx_en = 1'b0;
    push(8'h62);
    pop();
    chk("R8 disabled empty flag", 32'(empty), 32'h0);
    rx_en = 1'b1;
    pop();
    chk("R8 no leaked byte", 32'(empty), 32'h1);

    trig_level = 6'd2;
    for (int i = 0; i < 5; i++) push(8'(8'h70 + i));
    chk("R4 trig set", 32'(trig), 32'h1);
    do_flush();
    trig_level = 6'd32;

    repeat (6) @(negedge clk);
    chk("R7 no pulse while idle", 32'(rx_timeout), 32'h0);
    push(8'h81);
    tick(1'b0); tick(1'b0); tick(1'b0);
    push(8'h82);
    tick(1'b0); tick(1'b0); tick(1'b0);
    tick(1'b1);
    @(negedge clk);
    chk("R7 single pulse", 32'(rx_timeout), 32'h0);
    tick(1'b0); tick(1'b0); tick(1'b0); tick(1'b0); tick(1'b0);
    push(8'h83);
    tick(1'b0); tick(1'b0);
    do_flush();
    tick(1'b0); tick(1'b0); tick(1'b0); tick(1'b0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule